// File: doc/BRIEF.md
# Dual-Window Inbound DMA Address Translator

This block sits on the inbound path of a host bridge. Bus-master devices present addresses on the expansion bus, and the block turns each one into a host physical address through a small set of direct-mapped windows. Each window has three configuration values: a bus base, a size mask and a translated base. Because each window is aligned to a power of two, the low address bits inside the window pass through unchanged. The translated base supplies the upper bits. More than one window may point at the same physical memory. When several windows claim one address, the lowest-numbered window wins.

A per-request narrow flag marks traffic that comes from a legacy bridge, which drives only the low 27 address bits. For such a request the upper bits are taken as zero, and only window 0 may claim it. By default no window claims bus addresses below 64 MiB. That region stays free for device memory and legacy apertures.

Each translation result appears one clock after the request. Software changes the windows through a write-only port that selects one window and one field per write.

Top module: `dma_window_xlate`

## Requirements
- R1: After reset, window 0 is enabled with bus base 0x0400_0000, mask 0x03FF_FFFF (64 MiB) and translated base 0. Window 1 is enabled with bus base 0x4000_0000, mask 0x3FFF_FFFF (1 GiB) and translated base 0.
- R2: A window claims address A when it is enabled and (A & ~mask) equals (base & ~mask). The physical address it produces is (tbase & ~mask) | (A & mask).
- R3: When more than one window claims an address, the lowest-numbered window is reported in rsp_win and supplies rsp_paddr.
- R4: When no window claims a valid request, rsp_miss is 1, rsp_hit is 0, and rsp_win and rsp_paddr are 0.
- R5: With the reset configuration, addresses 0 to 0x03FF_FFFF miss. Addresses 0x0400_0000 to 0x07FF_FFFF map through window 0 to physical 0 to 0x03FF_FFFF. Addresses 0x4000_0000 to 0x7FFF_FFFF map through window 1 to physical 0 to 0x3FFF_FFFF. 0x0800_0000 to 0x3FFF_FFFF and addresses from 0x8000_0000 up miss.
- R6: When req_narrow is 1, address bits 31..27 are treated as zero and only window 0 may claim the request.
- R7: Bits of the base and translated-base values that fall inside the window (below the size) have no effect on matching or on the physical address.
- R8: rsp_valid is 1 exactly one cycle after req_valid is 1, and is 0 after reset. While rsp_valid is 0, rsp_hit and rsp_miss are 0.
- R9: When cfg_we is 1, cfg_wdata is written to the window that cfg_win names, into the field that cfg_field names: 0 for base, 1 for mask, 2 for translated base, 3 for enable (bit 0). A request presented in the same cycle as a write is translated with the values held before the write. The next request sees the new values.
- R10: A window whose enable is 0 claims no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 1 | Window selected by the write |
| cfg_field | input | 2 | Field selected: 0 base, 1 mask, 2 translated base, 3 enable |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Inbound request present |
| req_addr | input | 32 | Inbound bus address |
| req_narrow | input | 1 | Request from a 27-bit legacy bridge |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | Some window claimed the request |
| rsp_miss | output | 1 | No window claimed the request |
| rsp_win | output | 1 | Index of the claiming window |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
A configuration write and a translation request can fall in the same clock cycle. Because of that, the bench has to decide which configuration the request sees. The bench provokes this on purpose: it disables window 0 in the same cycle as a request that only window 0 can claim, and it expects a hit through window 0 with the old settings. The very next request to the same address must then miss. Apart from these directed cases, the bench mixes writes and requests at random. It checks every response against its own shadow copy of the written configuration, and that copy is updated only after the cycle of the write.

// File: rtl/dwx_pkg.sv
package dwx_pkg;

    localparam int unsigned DWX_AW         = 32;
    localparam int unsigned DWX_NWIN       = 2;
    localparam int unsigned DWX_NARROW_W   = 27;
    localparam int unsigned DWX_DEF_SHIFT0 = 26;
    localparam int unsigned DWX_DEF_STEP   = 4;

    typedef enum logic [1:0] {
        FLD_BASE  = 2'd0,
        FLD_MASK  = 2'd1,
        FLD_TBASE = 2'd2,
        FLD_EN    = 2'd3
    } cfg_fld_e;

    typedef struct packed {
        logic [DWX_AW-1:0] base;
        logic [DWX_AW-1:0] mask;
        logic [DWX_AW-1:0] tbase;
        logic              en;
    } win_cfg_t;

    // Window i defaults to base = size = 2^(26 + 4*i), mapped onto physical 0.
    function automatic win_cfg_t dwx_default_cfg(input int unsigned idx);
        win_cfg_t    c;
        int unsigned sh;
        sh = DWX_DEF_SHIFT0 + DWX_DEF_STEP * idx;
        if (sh > DWX_AW - 2) sh = DWX_AW - 2;
        c.base  = {{(DWX_AW-1){1'b0}}, 1'b1} << sh;
        c.mask  = c.base - {{(DWX_AW-1){1'b0}}, 1'b1};
        c.tbase = '0;
        c.en    = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/dwx_cfg_regs.sv
module dwx_cfg_regs
    import dwx_pkg::*;
#(
    parameter  int unsigned NWIN = DWX_NWIN,
    localparam int unsigned IW   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IW-1:0]     cfg_win,
    input  logic [1:0]        cfg_field,
    input  logic [DWX_AW-1:0] cfg_wdata,
    output win_cfg_t          cfg_o [NWIN]
);

    win_cfg_t cfg_d [NWIN];
    win_cfg_t cfg_q [NWIN];

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            for (int i = 0; i < NWIN; i++) begin
                if (cfg_win == IW'(i)) begin
                    case (cfg_fld_e'(cfg_field))
                        FLD_BASE:  cfg_d[i].base  = cfg_wdata;
                        FLD_MASK:  cfg_d[i].mask  = cfg_wdata;
                        FLD_TBASE: cfg_d[i].tbase = cfg_wdata;
                        FLD_EN:    cfg_d[i].en    = cfg_wdata[0];
                        default:   ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWIN; i++) cfg_q[i] <= dwx_default_cfg(i);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    for (genvar g = 0; g < NWIN; g++) begin : g_hold
        // R9
        cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_we |=> $stable(cfg_q[g]));
    end

endmodule

// File: rtl/dwx_win_match.sv
module dwx_win_match
    import dwx_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic [DWX_AW-1:0] addr,
    input  logic              allow,
    output logic              hit,
    output logic [DWX_AW-1:0] paddr
);

    logic [DWX_AW-1:0] tag_mask;

    always_comb begin
        tag_mask = ~cfg.mask;
        hit      = allow && cfg.en && ((addr & tag_mask) == (cfg.base & tag_mask));
        paddr    = (cfg.tbase & tag_mask) | (addr & cfg.mask);
    end

endmodule

// File: rtl/dma_window_xlate.sv
module dma_window_xlate
    import dwx_pkg::*;
#(
    parameter  int unsigned NWIN     = DWX_NWIN,
    parameter  int unsigned NARROW_W = DWX_NARROW_W,
    localparam int unsigned IW       = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IW-1:0]     cfg_win,
    input  logic [1:0]        cfg_field,
    input  logic [DWX_AW-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [DWX_AW-1:0] req_addr,
    input  logic              req_narrow,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [IW-1:0]     rsp_win,
    output logic [DWX_AW-1:0] rsp_paddr
);

    localparam logic [DWX_AW-1:0] NARROW_MASK = DWX_AW'((64'd1 << NARROW_W) - 64'd1);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              miss;
        logic [IW-1:0]     win;
        logic [DWX_AW-1:0] paddr;
    } rsp_t;

    win_cfg_t          cfg [NWIN];
    logic [DWX_AW-1:0] addr_eff;
    logic [NWIN-1:0]   hit_v;
    logic [DWX_AW-1:0] pa_v [NWIN];
    rsp_t              rsp_d, rsp_q;

    dwx_cfg_regs #(.NWIN(NWIN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_win   (cfg_win),
        .cfg_field (cfg_field),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg)
    );

    assign addr_eff = req_narrow ? (req_addr & NARROW_MASK) : req_addr;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam bit NARROW_OK = (g == 0);
        dwx_win_match u_match (
            .cfg   (cfg[g]),
            .addr  (addr_eff),
            .allow (NARROW_OK || !req_narrow),
            .hit   (hit_v[g]),
            .paddr (pa_v[g])
        );
    end

    // Static priority: scan from the top so the lowest index is written last.
    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            for (int i = NWIN - 1; i >= 0; i--) begin
                if (hit_v[i]) begin
                    rsp_d.hit   = 1'b1;
                    rsp_d.win   = IW'(i);
                    rsp_d.paddr = pa_v[i];
                end
            end
            rsp_d.miss = !rsp_d.hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_win   = rsp_q.win;
    assign rsp_paddr = rsp_q.paddr;

    // R8
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R8
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss));
    // R4
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));
    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_paddr == '0 && rsp_win == '0));
    // R6
    narrow_w0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_narrow) |=> (!rsp_hit || rsp_win == '0));
    // R3
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit_v[0]) |=> (rsp_hit && rsp_win == '0));
    // R10
    disabled_w0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg[0].en) |=> !(rsp_hit && rsp_win == '0));

endmodule

// File: tb/tb_dma_window_xlate.sv
`timescale 1ns/1ps
module tb_dma_window_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_win = '0;
    logic [1:0]  cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_narrow = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [0:0]  rsp_win;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int failures = 0;

    logic [31:0] sh_base  [2];
    logic [31:0] sh_mask  [2];
    logic [31:0] sh_tbase [2];
    logic        sh_en    [2];

    always #10 clk = ~clk;

    dma_window_xlate dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_narrow(req_narrow), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_win(rsp_win),
        .rsp_paddr(rsp_paddr)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected result from the requirements (R2, R3, R4, R6, R7, R10).
    function automatic logic [34:0] model(input logic [31:0] a, input bit nar);
        logic [31:0] ae;
        logic [34:0] r;
        ae = nar ? (a & 32'h07FF_FFFF) : a;
        r  = {1'b0, 1'b1, 1'b0, 32'h0};
        for (int i = 1; i >= 0; i--) begin
            if (sh_en[i] && (!nar || i == 0) &&
                ((ae & ~sh_mask[i]) == (sh_base[i] & ~sh_mask[i]))) begin
                r = {1'b1, 1'b0, 1'(i), (sh_tbase[i] & ~sh_mask[i]) | (ae & sh_mask[i])};
            end
        end
        return r;
    endfunction

    task automatic shadow_write(input int w, input int f, input logic [31:0] d);
        case (f)
            0: sh_base[w]  = d;
            1: sh_mask[w]  = d;
            2: sh_tbase[w] = d;
            default: sh_en[w] = d[0];
        endcase
    endtask

    // Optional write in the same cycle as a request; tasks start and end at negedge.
    task automatic cycle(input bit do_wr, input int w, input int f, input logic [31:0] d,
                         input bit do_rq, input logic [31:0] a, input bit nar, input string tag);
        logic [34:0] exp;
        exp        = model(a, nar);
        cfg_we     = do_wr;
        cfg_win    = 1'(w);
        cfg_field  = 2'(f);
        cfg_wdata  = d;
        req_valid  = do_rq;
        req_addr   = a;
        req_narrow = nar;
        @(posedge clk);
        @(negedge clk);
        cfg_we    = 1'b0;
        req_valid = 1'b0;
        if (do_wr) shadow_write(w, f, d);
        if (do_rq)
            check({rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_paddr} == {1'b1, exp}, tag,
                  {28'h0, rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_paddr}, {28'h0, 1'b1, exp});
    endtask

    task automatic req(input logic [31:0] a, input bit nar, input string tag);
        cycle(1'b0, 0, 0, 32'h0, 1'b1, a, nar, tag);
    endtask

    task automatic wr(input int w, input int f, input logic [31:0] d);
        cycle(1'b1, w, f, d, 1'b0, 32'h0, 1'b0, "");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        sh_base[0] = 32'h0400_0000; sh_mask[0] = 32'h03FF_FFFF; sh_tbase[0] = 0; sh_en[0] = 1;
        sh_base[1] = 32'h4000_0000; sh_mask[1] = 32'h3FFF_FFFF; sh_tbase[1] = 0; sh_en[1] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check(rsp_valid == 1'b0 && rsp_hit == 1'b0 && rsp_miss == 1'b0, "R8 reset",
              {61'h0, rsp_valid, rsp_hit, rsp_miss}, 64'h0);

        // R1 / R5 default windows
        req(32'h0400_0000, 0, "R1 w0 base");
        req(32'h07FF_FFFF, 0, "R5 w0 top");
        req(32'h03FF_FFFF, 0, "R5 below w0 miss");
        req(32'h0000_1000, 0, "R5 low miss");
        req(32'h4000_0000, 0, "R1 w1 base");
        req(32'h7FFF_FFF0, 0, "R5 w1 top");
        req(32'h8000_0000, 0, "R4 above w1 miss");
        req(32'h0800_0000, 0, "R5 gap miss");

        // R6 narrow mode
        req(32'h4400_0000, 1, "R6 narrow truncates into w0");
        req(32'h4000_0010, 1, "R6 narrow blocks w1");

        // R8 idle cycle gives no response
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8 idle", {63'h0, rsp_valid}, 64'h0);

        // R9 same-cycle write sees old config, then R10 disabled window
        cycle(1'b1, 0, 3, 32'h0, 1'b1, 32'h0400_0000, 0, "R9 write same cycle");
        req(32'h0400_0000, 0, "R10 disabled w0 miss");
        wr(0, 3, 32'h1);

        // R3 overlapping windows
        wr(1, 0, 32'h0);
        wr(1, 1, 32'h7FFF_FFFF);
        req(32'h0400_0100, 0, "R3 overlap w0 wins");
        req(32'h0100_0000, 0, "R3 only w1");
        wr(0, 3, 32'h0);
        req(32'h0400_0100, 0, "R10 w0 off w1 claims");
        wr(0, 3, 32'h1);

        // R7 low bits of base/tbase ignored
        wr(0, 0, 32'h0400_0ABC);
        wr(0, 2, 32'h1000_0123);
        req(32'h0400_0010, 0, "R7 low bits ignored");

        // R2 random configurations and addresses
        for (int n = 0; n < 600; n++) begin
            if (n % 40 == 0) begin
                for (int w = 0; w < 2; w++) begin
                    int k;
                    k = 12 + int'($urandom % 19);
                    wr(w, 1, (32'h1 << k) - 1);
                    wr(w, 0, $urandom);
                    wr(w, 2, $urandom);
                    wr(w, 3, {31'h0, ($urandom % 5) != 0});
                end
            end
            begin
                logic [31:0] a;
                int          w;
                bit          nar;
                w   = int'($urandom % 2);
                nar = ($urandom % 4) == 0;
                if ($urandom % 3 != 0) a = (sh_base[w] & ~sh_mask[w]) | ($urandom & sh_mask[w]);
                else a = $urandom;
                if ($urandom % 8 == 0)
                    cycle(1'b1, int'($urandom % 2), int'($urandom % 3) + 0, $urandom, 1'b1, a, nar, "R9 random write+req");
                else
                    req(a, nar, "R2 random");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule